// File: doc/BRIEF.md
# Vector State Control Register Unit

This unit keeps the packed vectorisation state of a hart: maximum vector length, a pointer to the scalar register holding the vector length, sub-vector length, source and destination element offsets, and the destination sub-vector offset. Software reaches it through a CSR-style access port that selects one of four views. Three of them are direct views of the maximum length, the length pointer and the sub-vector length. The fourth is the whole packed word. Writes to the three direct views are checked and raise an illegal flag when the value is out of range. Writes to the packed word never fault; out-of-range fields are clamped instead. Lengths sit in the packed word in minus-one form.

On trap entry into a privilege level, and on return from it, the live state trades places with a saved copy kept for that level. Nested traps therefore unwind transparently. The field outputs drive the element loop sequencer directly.

A small state machine tracks the response. In `ST_IDLE` there is no response. An accepted access moves it to `ST_RESP` (transition IDLE→RESP), where `rsp_valid` is high. It stays in `ST_RESP` if another access is accepted (RESP→RESP) and otherwise returns to idle (RESP→IDLE). A cycle with no accepted access leaves `ST_IDLE` unchanged (IDLE→IDLE).

Top module: `vstate_unit`

## Requirements
- R1: After reset the state is MVL = XLEN, length pointer 0, SUBVL = 1 and all offsets 0, so the packed word reads 0x0000003F when XLEN = 64. Every saved per-level copy starts with the same value.
- R2: Packed word layout, with lengths stored minus one:
  - MVL-1 in bits 5:0;
  - the length pointer in bits 11:6;
  - source offset in bits 17:12;
  - destination offset in bits 23:18;
  - SUBVL-1 in bits 25:24, so 1..4 are coded 00..11;
  - sub-vector destination offset in bits 27:26;
  - bits 31:28 always read 0.
- R3: Selectors are 0 = MVL, 1 = length pointer, 2 = SUBVL, 3 = packed word. Operations are 0 = read, 1 = register write, 2 = immediate write, 3 = reserved. An MVL write of 0 or of more than XLEN is illegal. Otherwise MVL becomes the minimum of the written value and the current MVL, both element offsets are clamped to the new MVL-1, and the old MVL is returned.
- R4: An immediate write to MVL or to the length pointer uses the immediate plus one, so an immediate of 0 means 1.
- R5: A write to the length pointer of 0 or of more than 31 is illegal. A legal write returns the new value, not the old one, and clears the source and destination offsets.
- R6: A SUBVL write of 0 or of more than 4 is illegal; an immediate write uses the raw immediate. A legal write returns the old SUBVL and clamps the sub-vector offset to the new SUBVL-1.
- R7: A packed-word write returns the old word and clamps each field:
  - MVL is capped at XLEN;
  - the pointer is capped at 31;
  - the source and destination offsets are capped at the new MVL-1, and forced to 0 when the pointer is 0;
  - the sub-vector offset is capped at SUBVL-1.
- R8: An illegal access returns read data 0, sets the illegal flag and leaves the state unchanged. Illegal accesses are a bad value, the reserved operation, and an immediate write to the packed word.
- R9: A read returns the true MVL, the pointer, the true SUBVL or the packed word, and changes nothing.
- R10: The response (`rsp_valid`, `rsp_rdata`, `rsp_illegal`) appears in the cycle after an accepted request and lasts one cycle.
- R11: A trap entry or exit strobe with level 0 (user), 1 (supervisor) or 3 (machine) swaps the live state with that level's saved copy. Level code 2 is ignored.
- R12: A valid trap strobe takes priority over a CSR request in the same cycle. That request is dropped: it gives no response and changes no state.
- R13: `vec_en` is high exactly when the length pointer is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_req | input | 1 | Access request strobe |
| csr_sel | input | 2 | View select: 0 MVL, 1 pointer, 2 SUBVL, 3 packed word |
| csr_op | input | 2 | 0 read, 1 register write, 2 immediate write, 3 reserved |
| csr_wdata | input | XLEN | Register write data |
| csr_imm | input | 5 | Immediate write value |
| rsp_valid | output | 1 | Response valid |
| rsp_rdata | output | XLEN | Response read data |
| rsp_illegal | output | 1 | Access rejected |
| trap_enter | input | 1 | Trap entry strobe |
| trap_exit | input | 1 | Trap return strobe |
| trap_lvl | input | 2 | Privilege level of the entry or return |
| mvl_len | output | 7 | Maximum vector length, 1..XLEN |
| vl_ptr | output | 5 | Scalar register number holding the length |
| vec_en | output | 1 | Vectorisation enabled |
| sub_len | output | 3 | Sub-vector length, 1..4 |
| src_offs | output | 6 | Source element offset |
| dst_offs | output | 6 | Destination element offset |
| dsv_offs | output | 2 | Destination sub-vector offset |

## Verification
The bench targets the following corner cases:
- The off-by-one encodings. A design that forgot the minus-one form would read the reset packed word as 0x40 instead of 0x3F. One that skipped the immediate plus-one would set the pointer to 4 instead of 5.
- Writes to the length pointer. A design that returned the old value here, or left the offsets alone, would report stale offsets to the sequencer.
- Packed-word clamping: a pointer of 40, a destination offset above MVL-1, offsets written while the pointer is 0, and a sub-vector offset of 3 under SUBVL 3. Without the clamps, offsets would point past the vector.
- Nested trap entry and exit. Swapping with the wrong level's copy would return a user context into supervisor state.
- A trap arriving together with a CSR write. A design that let the write through would corrupt the context being saved.

// File: rtl/vstate_pkg.sv
package vstate_pkg;

    // Packed state, most significant field first, matching the CSR bit layout.
    typedef struct packed {
        logic [1:0] dsv;
        logic [1:0] sub_m1;
        logic [5:0] dst;
        logic [5:0] src;
        logic [5:0] vl;
        logic [5:0] mvl_m1;
    } vstate_t;

    localparam int STATE_BITS = $bits(vstate_t);
    localparam int WORD_BITS  = 32;
    localparam int NUM_LVL    = 3;

    typedef enum logic [1:0] {
        SEL_MVL   = 2'd0,
        SEL_VL    = 2'd1,
        SEL_SUBVL = 2'd2,
        SEL_STATE = 2'd3
    } vsel_e;

    typedef enum logic [1:0] {
        OP_READ      = 2'd0,
        OP_WRITE     = 2'd1,
        OP_WRITE_IMM = 2'd2,
        OP_RSVD      = 2'd3
    } vop_e;

    typedef enum logic [1:0] {
        LVL_U    = 2'd0,
        LVL_S    = 2'd1,
        LVL_RSVD = 2'd2,
        LVL_M    = 2'd3
    } vlvl_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } vfsm_e;

    function automatic vstate_t vst_reset(int unsigned xlen);
        vstate_t s;
        s        = '0;
        s.mvl_m1 = 6'(xlen - 1);
        return s;
    endfunction

    function automatic logic [1:0] lvl_code(int idx);
        case (idx)
            0:       return LVL_U;
            1:       return LVL_S;
            default: return LVL_M;
        endcase
    endfunction

    function automatic logic [5:0] clamp6(logic [5:0] v, logic [5:0] lim);
        return (v > lim) ? lim : v;
    endfunction

endpackage

// File: rtl/vstate_eval.sv
module vstate_eval
    import vstate_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int NREG    = 32,
    parameter int MAX_SUB = 4
) (
    input  vstate_t           cur,
    input  logic [1:0]        op,
    input  logic [1:0]        sel,
    input  logic [XLEN-1:0]   wdata,
    input  logic [4:0]        imm,
    output vstate_t           nxt,
    output logic [XLEN-1:0]   rdata,
    output logic              illegal
);
    localparam logic [6:0]      MVL_CAP = 7'(XLEN);
    localparam logic [5:0]      VL_TOP  = 6'(NREG - 1);
    localparam logic [XLEN-1:0] XLEN_V  = XLEN'(XLEN);
    localparam logic [XLEN-1:0] VLTOP_V = XLEN'(NREG - 1);
    localparam logic [XLEN-1:0] SUB_V   = XLEN'(MAX_SUB);

    logic [XLEN-1:0] len_val;
    logic [XLEN-1:0] raw_val;
    logic [6:0]      mvl_cur;
    logic [6:0]      mvl_pick;
    logic [6:0]      st_mvl_raw;
    logic [6:0]      st_mvl;
    logic [5:0]      st_vl;
    logic [5:0]      st_lim;
    logic [2:0]      sub_cur;
    vstate_t         wr_word;

    always_comb begin
        len_val    = (op == OP_WRITE_IMM) ? (XLEN'(imm) + XLEN'(1)) : wdata;
        raw_val    = (op == OP_WRITE_IMM) ? XLEN'(imm) : wdata;
        mvl_cur    = {1'b0, cur.mvl_m1} + 7'd1;
        sub_cur    = {1'b0, cur.sub_m1} + 3'd1;
        mvl_pick   = (len_val[6:0] < mvl_cur) ? len_val[6:0] : mvl_cur;
        wr_word    = vstate_t'(wdata[STATE_BITS-1:0]);
        st_mvl_raw = {1'b0, wr_word.mvl_m1} + 7'd1;
        st_mvl     = (st_mvl_raw > MVL_CAP) ? MVL_CAP : st_mvl_raw;
        st_vl      = (wr_word.vl > VL_TOP) ? VL_TOP : wr_word.vl;
        st_lim     = (st_vl == 6'd0) ? 6'd0 : 6'(st_mvl - 7'd1);

        nxt     = cur;
        rdata   = '0;
        illegal = 1'b0;

        if (op == OP_RSVD) begin
            illegal = 1'b1;
        end else begin
            case (sel)
                SEL_MVL: begin
                    if (op == OP_READ) begin
                        rdata = XLEN'(mvl_cur);
                    end else if (len_val == '0 || len_val > XLEN_V) begin
                        illegal = 1'b1;
                    end else begin
                        nxt.mvl_m1 = 6'(mvl_pick - 7'd1);
                        nxt.src    = clamp6(cur.src, 6'(mvl_pick - 7'd1));
                        nxt.dst    = clamp6(cur.dst, 6'(mvl_pick - 7'd1));
                        rdata      = XLEN'(mvl_cur);
                    end
                end
                SEL_VL: begin
                    if (op == OP_READ) begin
                        rdata = XLEN'(cur.vl);
                    end else if (len_val == '0 || len_val > VLTOP_V) begin
                        illegal = 1'b1;
                    end else begin
                        nxt.vl  = len_val[5:0];
                        nxt.src = '0;
                        nxt.dst = '0;
                        rdata   = XLEN'(len_val[5:0]);
                    end
                end
                SEL_SUBVL: begin
                    if (op == OP_READ) begin
                        rdata = XLEN'(sub_cur);
                    end else if (raw_val == '0 || raw_val > SUB_V) begin
                        illegal = 1'b1;
                    end else begin
                        nxt.sub_m1 = 2'(raw_val[2:0] - 3'd1);
                        nxt.dsv    = (cur.dsv > 2'(raw_val[2:0] - 3'd1))
                                     ? 2'(raw_val[2:0] - 3'd1) : cur.dsv;
                        rdata      = XLEN'(sub_cur);
                    end
                end
                default: begin
                    if (op == OP_READ) begin
                        rdata = XLEN'({{(WORD_BITS-STATE_BITS){1'b0}}, cur});
                    end else if (op == OP_WRITE_IMM) begin
                        illegal = 1'b1;
                    end else begin
                        nxt.mvl_m1 = 6'(st_mvl - 7'd1);
                        nxt.vl     = st_vl;
                        nxt.src    = clamp6(wr_word.src, st_lim);
                        nxt.dst    = clamp6(wr_word.dst, st_lim);
                        nxt.sub_m1 = wr_word.sub_m1;
                        nxt.dsv    = (wr_word.dsv > wr_word.sub_m1) ? wr_word.sub_m1 : wr_word.dsv;
                        rdata      = XLEN'({{(WORD_BITS-STATE_BITS){1'b0}}, cur});
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/vstate_bank.sv
module vstate_bank
    import vstate_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       swap_en,
    input  logic [1:0] swap_lvl,
    input  vstate_t    live,
    output vstate_t    saved,
    output logic       hit
);
    localparam vstate_t RST_VAL = vst_reset(XLEN);

    logic [NUM_LVL-1:0] hit_vec;
    vstate_t            slot_arr [NUM_LVL];

    for (genvar i = 0; i < NUM_LVL; i++) begin : g_slot
        localparam logic [1:0] CODE = lvl_code(i);
        vstate_t slot_q;

        assign hit_vec[i] = (swap_lvl == CODE);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= RST_VAL;
            end else if (swap_en && hit_vec[i]) begin
                slot_q <= live;
            end
        end

        assign slot_arr[i] = slot_q;
    end

    always_comb begin
        saved = '0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (hit_vec[i]) begin
                saved = slot_arr[i];
            end
        end
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/vstate_unit.sv
module vstate_unit
    import vstate_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int NREG    = 32,
    parameter int MAX_SUB = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_req,
    input  logic [1:0]      csr_sel,
    input  logic [1:0]      csr_op,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic [4:0]      csr_imm,
    output logic            rsp_valid,
    output logic [XLEN-1:0] rsp_rdata,
    output logic            rsp_illegal,
    input  logic            trap_enter,
    input  logic            trap_exit,
    input  logic [1:0]      trap_lvl,
    output logic [6:0]      mvl_len,
    output logic [4:0]      vl_ptr,
    output logic            vec_en,
    output logic [2:0]      sub_len,
    output logic [5:0]      src_offs,
    output logic [5:0]      dst_offs,
    output logic [1:0]      dsv_offs
);
    localparam vstate_t RST_VAL = vst_reset(XLEN);

    vfsm_e           state_q;
    vfsm_e           state_d;
    vstate_t         live_q;
    vstate_t         eval_nxt;
    vstate_t         bank_out;
    logic [XLEN-1:0] eval_rdata;
    logic            eval_ill;
    logic            bank_hit;
    logic            swap_req;
    logic            swap_go;
    logic            accept;
    logic [XLEN-1:0] rdata_q;
    logic            illegal_q;

    assign swap_req = trap_enter | trap_exit;
    assign swap_go  = swap_req & bank_hit;
    assign accept   = csr_req & ~swap_go;

    vstate_eval #(.XLEN(XLEN), .NREG(NREG), .MAX_SUB(MAX_SUB)) eval_i (
        .cur     (live_q),
        .op      (csr_op),
        .sel     (csr_sel),
        .wdata   (csr_wdata),
        .imm     (csr_imm),
        .nxt     (eval_nxt),
        .rdata   (eval_rdata),
        .illegal (eval_ill)
    );

    vstate_bank #(.XLEN(XLEN)) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .swap_en  (swap_req),
        .swap_lvl (trap_lvl),
        .live     (live_q),
        .saved    (bank_out),
        .hit      (bank_hit)
    );

    // Live state: a trap swap outranks any CSR update.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= RST_VAL;
        end else if (swap_go) begin
            live_q <= bank_out;
        end else if (accept) begin
            live_q <= eval_nxt;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = accept ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = accept ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q   <= '0;
            illegal_q <= 1'b0;
        end else if (accept) begin
            rdata_q   <= eval_rdata;
            illegal_q <= eval_ill;
        end
    end

    assign rsp_valid   = (state_q == ST_RESP);
    assign rsp_rdata   = rdata_q;
    assign rsp_illegal = illegal_q;

    assign mvl_len  = {1'b0, live_q.mvl_m1} + 7'd1;
    assign vl_ptr   = live_q.vl[4:0];
    assign vec_en   = (live_q.vl != 6'd0);
    assign sub_len  = {1'b0, live_q.sub_m1} + 3'd1;
    assign src_offs = live_q.src;
    assign dst_offs = live_q.dst;
    assign dsv_offs = live_q.dsv;

endmodule

// File: rtl/vstate_chk.sv
module vstate_chk
    import vstate_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            csr_req,
    input logic [1:0]      csr_sel,
    input logic [1:0]      csr_op,
    input logic            rsp_valid,
    input logic [XLEN-1:0] rsp_rdata,
    input logic            rsp_illegal,
    input logic            trap_enter,
    input logic            trap_exit,
    input logic [1:0]      trap_lvl,
    input logic [6:0]      mvl_len,
    input logic [4:0]      vl_ptr,
    input logic [2:0]      sub_len,
    input logic [5:0]      src_offs,
    input logic [5:0]      dst_offs,
    input logic [1:0]      dsv_offs
);
    logic trap_valid;
    assign trap_valid = (trap_enter || trap_exit) && (trap_lvl != LVL_RSVD);

    a_r7_offs_within_mvl: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, src_offs} < mvl_len) && ({1'b0, dst_offs} < mvl_len));

    a_r6_dsv_within_subvl: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_len >= 3'd1) && (sub_len <= 3'd4) && ({1'b0, dsv_offs} < sub_len));

    a_r8_illegal_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_illegal) |->
            ($stable({mvl_len, vl_ptr, sub_len, src_offs, dst_offs, dsv_offs}) && rsp_rdata == '0));

    a_r5_vl_returns_new: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_illegal && $past(csr_sel) == SEL_VL && $past(csr_op) != OP_READ)
            |-> (rsp_rdata == XLEN'(vl_ptr)));

    a_r12_trap_drops_request: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> !rsp_valid);

    a_r10_response_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && !trap_valid) |=> rsp_valid);

endmodule

bind vstate_unit vstate_chk #(.XLEN(XLEN)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_req     (csr_req),
    .csr_sel     (csr_sel),
    .csr_op      (csr_op),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .rsp_illegal (rsp_illegal),
    .trap_enter  (trap_enter),
    .trap_exit   (trap_exit),
    .trap_lvl    (trap_lvl),
    .mvl_len     (mvl_len),
    .vl_ptr      (vl_ptr),
    .sub_len     (sub_len),
    .src_offs    (src_offs),
    .dst_offs    (dst_offs),
    .dsv_offs    (dsv_offs)
);

// File: tb/vstate_unit_tb_top.sv
module vstate_unit_tb_top;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            csr_req = 1'b0;
    logic [1:0]      csr_sel = 2'd0;
    logic [1:0]      csr_op = 2'd0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic [4:0]      csr_imm = 5'd0;
    logic            trap_enter = 1'b0;
    logic            trap_exit = 1'b0;
    logic [1:0]      trap_lvl = 2'd0;
    logic            rsp_valid;
    logic [XLEN-1:0] rsp_rdata;
    logic            rsp_illegal;
    logic [6:0]      mvl_len;
    logic [4:0]      vl_ptr;
    logic            vec_en;
    logic [2:0]      sub_len;
    logic [5:0]      src_offs;
    logic [5:0]      dst_offs;
    logic [1:0]      dsv_offs;

    int n_chk = 0;
    int n_bad = 0;
    logic            r_vld;
    logic            r_ill;
    logic [XLEN-1:0] r_rd;

    always #4 clk = ~clk;

    vstate_unit #(.XLEN(XLEN)) dut_i (.*);

    // Encodings per R2 / R3
    localparam logic [1:0] S_MVL = 2'd0, S_VL = 2'd1, S_SUB = 2'd2, S_ST = 2'd3;
    localparam logic [1:0] O_RD = 2'd0, O_WR = 2'd1, O_IMM = 2'd2, O_BAD = 2'd3;

    function automatic logic [31:0] pk(int mvl, int vl, int src, int dst, int sub, int dsv);
        return 32'(mvl - 1) | (32'(vl) << 6) | (32'(src) << 12) | (32'(dst) << 18)
             | (32'(sub - 1) << 24) | (32'(dsv) << 26);
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_fields(string tag, logic [31:0] exp);
        chk(tag, 64'(pk(int'(mvl_len), int'(vl_ptr), int'(src_offs), int'(dst_offs),
                        int'(sub_len), int'(dsv_offs))), 64'(exp));
    endtask

    task automatic csr(logic [1:0] op, logic [1:0] sel, logic [63:0] wd, logic [4:0] im);
        @(negedge clk);
        csr_req = 1'b1; csr_op = op; csr_sel = sel; csr_wdata = wd; csr_imm = im;
        @(negedge clk);
        csr_req = 1'b0;
        r_vld = rsp_valid; r_ill = rsp_illegal; r_rd = rsp_rdata;
    endtask

    task automatic expect_ok(string tag, logic [63:0] rd);
        chk({tag, " valid"}, 64'(r_vld), 64'd1);
        chk({tag, " illegal"}, 64'(r_ill), 64'd0);
        chk({tag, " rdata"}, r_rd, rd);
    endtask

    task automatic expect_bad(string tag);
        chk({tag, " illegal"}, 64'(r_ill), 64'd1);
        chk({tag, " rdata0"}, r_rd, 64'd0);
    endtask

    task automatic trap(logic ent, logic [1:0] lvl);
        @(negedge clk);
        trap_enter = ent; trap_exit = ~ent; trap_lvl = lvl;
        @(negedge clk);
        trap_enter = 1'b0; trap_exit = 1'b0;
    endtask

    task automatic t_reset;
        chk_fields("R1 reset fields", pk(64, 0, 0, 0, 1, 0));
        chk("R13 vec_en reset", 64'(vec_en), 64'd0);
        chk("R10 no response at reset", 64'(rsp_valid), 64'd0);
        csr(O_RD, S_ST, 0, 0);
        expect_ok("R1 R2 reset packed", 64'h3F);
        @(negedge clk);
        chk("R10 response one cycle", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_state_write;
        // mvl field 15, vl 40, src 5, dst 50, sub code 2, dsv 3, reserved set
        csr(O_WR, S_ST, 64'(32'hF000_0000 | 32'd15 | (32'd40 << 6) | (32'd5 << 12)
                         | (32'd50 << 18) | (32'd2 << 24) | (32'd3 << 26)), 0);
        expect_ok("R7 state write old", 64'h3F);
        chk_fields("R7 state clamps", pk(16, 31, 5, 15, 3, 2));
        csr(O_RD, S_ST, 0, 0);
        expect_ok("R2 packed readback", 64'(pk(16, 31, 5, 15, 3, 2)));
    endtask

    task automatic t_vl;
        csr(O_WR, S_VL, 10, 0);
        expect_ok("R5 vl new value", 64'd10);
        chk_fields("R5 vl clears offsets", pk(16, 10, 0, 0, 3, 2));
        chk("R13 vec_en set", 64'(vec_en), 64'd1);
        csr(O_IMM, S_VL, 0, 5'd4);
        expect_ok("R4 vl imm plus one", 64'd5);
        csr(O_WR, S_VL, 0, 0);
        expect_bad("R5 vl zero");
        csr(O_WR, S_VL, 32, 0);
        expect_bad("R5 vl above 31");
        csr(O_IMM, S_VL, 0, 5'd31);
        expect_bad("R5 vl imm 31");
        chk_fields("R8 vl unchanged", pk(16, 5, 0, 0, 3, 2));
    endtask

    task automatic t_mvl;
        csr(O_WR, S_ST, 64'(pk(16, 5, 12, 3, 1, 0)), 0);
        expect_ok("R7 state old word", 64'(pk(16, 5, 0, 0, 3, 2)));
        csr(O_WR, S_MVL, 0, 0);
        expect_bad("R3 mvl zero");
        csr(O_WR, S_MVL, 65, 0);
        expect_bad("R3 mvl above xlen");
        csr(O_WR, S_MVL, 40, 0);
        expect_ok("R3 mvl min keeps", 64'd16);
        chk_fields("R3 mvl min fields", pk(16, 5, 12, 3, 1, 0));
        csr(O_WR, S_MVL, 8, 0);
        expect_ok("R3 mvl old value", 64'd16);
        chk_fields("R3 mvl clamps offsets", pk(8, 5, 7, 3, 1, 0));
        csr(O_IMM, S_MVL, 0, 5'd1);
        expect_ok("R4 mvl imm", 64'd8);
        chk_fields("R4 mvl imm fields", pk(2, 5, 1, 1, 1, 0));
        csr(O_RD, S_MVL, 0, 0);
        expect_ok("R9 mvl read true", 64'd2);
    endtask

    task automatic t_subvl;
        csr(O_WR, S_ST, 64'(32'd63 | (32'd9 << 12) | (32'd9 << 18) | (32'd3 << 24) | (32'd3 << 26)), 0);
        chk_fields("R7 vl zero forces offsets", pk(64, 0, 0, 0, 4, 3));
        chk("R13 vec_en clear", 64'(vec_en), 64'd0);
        csr(O_WR, S_SUB, 2, 0);
        expect_ok("R6 subvl old", 64'd4);
        chk_fields("R6 dsv clamp", pk(64, 0, 0, 0, 2, 1));
        csr(O_WR, S_SUB, 0, 0);
        expect_bad("R6 subvl zero");
        csr(O_WR, S_SUB, 5, 0);
        expect_bad("R6 subvl five");
        csr(O_IMM, S_SUB, 0, 5'd0);
        expect_bad("R6 subvl imm zero");
        csr(O_IMM, S_SUB, 0, 5'd3);
        expect_ok("R6 subvl imm raw", 64'd2);
        csr(O_RD, S_SUB, 0, 0);
        expect_ok("R9 subvl read", 64'd3);
    endtask

    task automatic t_illegal;
        csr(O_BAD, S_VL, 9, 0);
        expect_bad("R8 reserved op");
        csr(O_IMM, S_ST, 0, 5'd7);
        expect_bad("R8 state imm");
        csr(O_RD, S_ST, 0, 0);
        expect_ok("R8 R9 state intact", 64'(pk(64, 0, 0, 0, 3, 1)));
    endtask

    task automatic t_trap;
        logic [31:0] a, b, c, rst_w;
        a = pk(64, 0, 0, 0, 3, 1);
        b = pk(20, 7, 3, 4, 2, 1);
        c = pk(4, 2, 1, 2, 4, 3);
        rst_w = pk(64, 0, 0, 0, 1, 0);
        trap(1'b1, 2'd0);
        chk_fields("R11 enter U gets saved reset", rst_w);
        csr(O_WR, S_ST, 64'(b), 0);
        trap(1'b1, 2'd3);
        chk_fields("R11 enter M", rst_w);
        csr(O_WR, S_ST, 64'(c), 0);
        chk_fields("R11 M context", c);
        trap(1'b0, 2'd3);
        chk_fields("R11 exit M restores", b);
        trap(1'b0, 2'd0);
        chk_fields("R11 exit U restores", a);
        trap(1'b1, 2'd2);
        chk_fields("R11 level 2 ignored", a);
        // R12: trap and request together
        @(negedge clk);
        csr_req = 1'b1; csr_op = O_WR; csr_sel = S_VL; csr_wdata = 9;
        trap_enter = 1'b1; trap_lvl = 2'd1;
        @(negedge clk);
        csr_req = 1'b0; trap_enter = 1'b0;
        chk("R12 no response", 64'(rsp_valid), 64'd0);
        chk_fields("R12 swap wins", rst_w);
        trap(1'b0, 2'd1);
        chk_fields("R12 write dropped", a);
        // invalid level does not block a request
        @(negedge clk);
        csr_req = 1'b1; csr_op = O_WR; csr_sel = S_VL; csr_wdata = 9;
        trap_enter = 1'b1; trap_lvl = 2'd2;
        @(negedge clk);
        csr_req = 1'b0; trap_enter = 1'b0;
        chk("R11 level 2 request served", 64'(rsp_valid), 64'd1);
        chk("R11 level 2 vl", 64'(vl_ptr), 64'd9);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_state_write();
        t_vl();
        t_mvl();
        t_subvl();
        t_illegal();
        t_trap();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule